// File: doc/BRIEF.md
# LUT-Driven Arithmetic Logic Element Chain

This block models a configurable logic element in arithmetic mode. Each element holds four 4-input lookup tables arranged in two halves. Each table is set by a 16-bit truth-table mask. In each half, two tables feed a dedicated one-bit full adder. The two adders in an element are chained, so each one adds the outputs of two arbitrary four-input functions plus an incoming carry. Any logic placed before the adder costs nothing extra.

The top module places `N` elements in a ripple-carry chain, which gives a `2N`-bit datapath. With pass-through masks it works as an adder. When the second table of each half inverts its operand and the chain carry-in is held high, it works as a magnitude comparator: the final carry is the result, the sum bits are not needed, and the raw table outputs stay usable at the same time. Every sum bit is available directly as a combinational output and also through a flip-flop that has a synchronous reset and a clock enable.

Top module: `lut_arith_chain`

## Requirements
- R1: Each table output equals bit `idx` of its 16-bit mask, where `idx = {in3,in2,in1,in0}`. For element i, `in0 = sh_a[i]` and `in1 = sh_b[i]`. Table k of element i uses `mask[64*i+16*k +: 16]` and drives `lut_out[4*i+k]`. Its in2 is `sh_c[i]` for k=0,2 and `sh_d[i]` for k=1,3. Its in3 is `lo_e[i]`, `lo_f[i]`, `hi_e[i]`, `hi_f[i]` for k=0..3.
- R2: `sum_comb[2i]` is the low bit of table0 + table1 + carry into element i. The carry into element 0 is `cin`.
- R3: `sum_comb[2i+1]` is the low bit of table2 + table3 + the carry produced by the lower adder of the same element.
- R4: The carry out of each element's upper adder is the carry into element i+1. The last element's upper carry drives `cout`.
- R5: With every mask set to 16'hFF00, let X have bits `lo_e[i]` at 2i and `hi_e[i]` at 2i+1. Let Y be formed the same way from `lo_f` and `hi_f`. Then `{cout, sum_comb}` equals X + Y + cin.
- R6: On a rising clock edge with `rst` low and `ce` high, `sum_reg` takes the value of `sum_comb`. With `ce` low it keeps its value.
- R7: On a rising clock edge with `rst` high, `sum_reg` becomes zero whatever the value of `ce`.
- R8: With masks 16'hFF00 on tables 0 and 2, 16'h00FF on tables 1 and 3, and `cin` high, `cout` is 1 exactly when X >= Y (X and Y as in R5). `lut_out` still follows R1 during this use.
- R9: `sum_comb`, `cout` and `lut_out` respond to input changes without a clock edge, and `sum_reg` does not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the sum registers |
| rst | input | 1 | Synchronous active-high reset of the sum registers |
| ce | input | 1 | Clock enable of the sum registers |
| cin | input | 1 | Carry into element 0 |
| sh_a | input | N | Per element: index bit 0 shared by all four tables |
| sh_b | input | N | Per element: index bit 1 shared by all four tables |
| sh_c | input | N | Per element: index bit 2 of tables 0 and 2 |
| sh_d | input | N | Per element: index bit 2 of tables 1 and 3 |
| lo_e | input | N | Per element: index bit 3 of table 0 |
| lo_f | input | N | Per element: index bit 3 of table 1 |
| hi_e | input | N | Per element: index bit 3 of table 2 |
| hi_f | input | N | Per element: index bit 3 of table 3 |
| mask | input | 64*N | Truth-table masks, 16 bits per table |
| lut_out | output | 4*N | Combinational table outputs |
| sum_comb | output | 2*N | Unregistered sum bits |
| sum_reg | output | 2*N | Registered sum bits |
| cout | output | 1 | Carry out of the last element |

## Verification
The bench builds the chain with N = 4. That gives an 8-bit datapath in which the carry crosses three element boundaries and one internal adder link per element. The full carry sweep is therefore reachable, for example 8'hFF + 8'h00 with a carry-in. The comparator use and the equality boundary can be checked on operands small enough to hit the corner values deliberately. The bench also applies random masks, which exercise every table index position, and random clock-enable and reset patterns against the registered outputs.

// File: rtl/lut_arith_cell.sv
module lut_arith_cell (
  input  logic        clk,
  input  logic        rst,
  input  logic        ce,
  input  logic        a,
  input  logic        b,
  input  logic        c,
  input  logic        d,
  input  logic        e0,
  input  logic        f0,
  input  logic        e1,
  input  logic        f1,
  input  logic        cin,
  input  logic [63:0] mask,
  output logic [3:0]  lut,
  output logic [1:0]  sum,
  output logic [1:0]  sum_q,
  output logic        cout
);
  logic mid_carry;

  assign lut[0] = mask[{2'd0, e0, c, b, a}];
  assign lut[1] = mask[{2'd1, f0, d, b, a}];
  assign lut[2] = mask[{2'd2, e1, c, b, a}];
  assign lut[3] = mask[{2'd3, f1, d, b, a}];

  assign {mid_carry, sum[0]} = {1'b0, lut[0]} + {1'b0, lut[1]} + {1'b0, cin};
  assign {cout, sum[1]}      = {1'b0, lut[2]} + {1'b0, lut[3]} + {1'b0, mid_carry};

  always_ff @(posedge clk) begin
    if (rst)     sum_q <= '0;
    else if (ce) sum_q <= sum;
  end
endmodule

// File: rtl/lut_arith_chain.sv
module lut_arith_chain #(
  parameter int N = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic            cin,
  input  logic [N-1:0]    sh_a,
  input  logic [N-1:0]    sh_b,
  input  logic [N-1:0]    sh_c,
  input  logic [N-1:0]    sh_d,
  input  logic [N-1:0]    lo_e,
  input  logic [N-1:0]    lo_f,
  input  logic [N-1:0]    hi_e,
  input  logic [N-1:0]    hi_f,
  input  logic [64*N-1:0] mask,
  output logic [4*N-1:0]  lut_out,
  output logic [2*N-1:0]  sum_comb,
  output logic [2*N-1:0]  sum_reg,
  output logic            cout
);
  logic [N:0] carry;

  assign carry[0] = cin;
  assign cout     = carry[N];

  for (genvar i = 0; i < N; i++) begin : g_cell
    lut_arith_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .ce    (ce),
      .a     (sh_a[i]),
      .b     (sh_b[i]),
      .c     (sh_c[i]),
      .d     (sh_d[i]),
      .e0    (lo_e[i]),
      .f0    (lo_f[i]),
      .e1    (hi_e[i]),
      .f1    (hi_f[i]),
      .cin   (carry[i]),
      .mask  (mask[64*i +: 64]),
      .lut   (lut_out[4*i +: 4]),
      .sum   (sum_comb[2*i +: 2]),
      .sum_q (sum_reg[2*i +: 2]),
      .cout  (carry[i+1])
    );
  end
endmodule

// File: rtl/lut_arith_chain_chk.sv
module lut_arith_chain_chk #(
  parameter int N = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ce,
  input logic            cin,
  input logic [N-1:0]    lo_e,
  input logic [N-1:0]    lo_f,
  input logic [N-1:0]    hi_e,
  input logic [N-1:0]    hi_f,
  input logic [64*N-1:0] mask,
  input logic [4*N-1:0]  lut_out,
  input logic [2*N-1:0]  sum_comb,
  input logic [2*N-1:0]  sum_reg,
  input logic            cout
);
  logic [2*N-1:0] op_x, op_y;
  logic pass_cfg, cmp_cfg;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      op_x[2*i]   = lo_e[i];
      op_x[2*i+1] = hi_e[i];
      op_y[2*i]   = lo_f[i];
      op_y[2*i+1] = hi_f[i];
    end
  end

  assign pass_cfg = (mask == {4*N{16'hFF00}});
  assign cmp_cfg  = (mask == {2*N{16'h00FF, 16'hFF00}});

  assert_reset_clears_R7: assert property (@(posedge clk) rst |=> sum_reg == '0);

  assert_reg_loads_R6: assert property (@(posedge clk) disable iff (rst)
    ce |=> sum_reg == $past(sum_comb));

  assert_reg_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(sum_reg));

  assert_pass_add_R5: assert property (@(posedge clk) disable iff (rst)
    pass_cfg |-> {cout, sum_comb} == ({1'b0, op_x} + {1'b0, op_y} + {{2*N{1'b0}}, cin}));

  assert_compare_R8: assert property (@(posedge clk) disable iff (rst)
    (cmp_cfg && cin) |-> cout == (op_x >= op_y));

  assert_zero_mask_R1: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |-> (lut_out == '0 && sum_comb == {{2*N-1{1'b0}}, cin} && !cout));
endmodule

bind lut_arith_chain lut_arith_chain_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .cin(cin),
  .lo_e(lo_e), .lo_f(lo_f), .hi_e(hi_e), .hi_f(hi_f),
  .mask(mask), .lut_out(lut_out), .sum_comb(sum_comb),
  .sum_reg(sum_reg), .cout(cout)
);

// File: tb/lut_arith_chain_bench.sv
module lut_arith_chain_bench;
  localparam int N = 4;
  localparam int W = 2 * N;

  logic clk = 0, rst = 1, ce = 0, cin = 0;
  logic [N-1:0] sh_a = '0, sh_b = '0, sh_c = '0, sh_d = '0;
  logic [N-1:0] lo_e = '0, lo_f = '0, hi_e = '0, hi_f = '0;
  logic [64*N-1:0] mask = '0;
  logic [4*N-1:0] lut_out;
  logic [W-1:0] sum_comb, sum_reg;
  logic cout;

  int checks = 0, errors = 0;
  logic [W-1:0] exp_reg = '0;
  logic [4*N-1:0] e_lut;
  logic [W-1:0] e_sum;
  logic e_cout;

  always #5 clk = ~clk;

  lut_arith_chain #(.N(N)) u_lut_arith_chain (
    .clk(clk), .rst(rst), .ce(ce), .cin(cin),
    .sh_a(sh_a), .sh_b(sh_b), .sh_c(sh_c), .sh_d(sh_d),
    .lo_e(lo_e), .lo_f(lo_f), .hi_e(hi_e), .hi_f(hi_f),
    .mask(mask), .lut_out(lut_out), .sum_comb(sum_comb),
    .sum_reg(sum_reg), .cout(cout)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model();
    int carry = cin;
    for (int i = 0; i < N; i++) begin
      int base = 64 * i;
      int ia = sh_a[i] + 2 * sh_b[i];
      int t0 = mask[base + ia + 4 * sh_c[i] + 8 * lo_e[i]];
      int t1 = mask[base + 16 + ia + 4 * sh_d[i] + 8 * lo_f[i]];
      int t2 = mask[base + 32 + ia + 4 * sh_c[i] + 8 * hi_e[i]];
      int t3 = mask[base + 48 + ia + 4 * sh_d[i] + 8 * hi_f[i]];
      int s;
      e_lut[4*i]   = t0[0];
      e_lut[4*i+1] = t1[0];
      e_lut[4*i+2] = t2[0];
      e_lut[4*i+3] = t3[0];
      s = t0 + t1 + carry;
      e_sum[2*i] = s[0];
      carry = s / 2;
      s = t2 + t3 + carry;
      e_sum[2*i+1] = s[0];
      carry = s / 2;
    end
    e_cout = carry[0];
  endtask

  function automatic logic [W-1:0] pack_x();
    logic [W-1:0] v;
    for (int i = 0; i < N; i++) begin v[2*i] = lo_e[i]; v[2*i+1] = hi_e[i]; end
    return v;
  endfunction

  function automatic logic [W-1:0] pack_y();
    logic [W-1:0] v;
    for (int i = 0; i < N; i++) begin v[2*i] = lo_f[i]; v[2*i+1] = hi_f[i]; end
    return v;
  endfunction

  task automatic set_ops(input logic [W-1:0] x, input logic [W-1:0] y);
    for (int i = 0; i < N; i++) begin
      lo_e[i] = x[2*i]; hi_e[i] = x[2*i+1];
      lo_f[i] = y[2*i]; hi_f[i] = y[2*i+1];
    end
  endtask

  task automatic rand_side();
    {sh_a, sh_b, sh_c, sh_d} = $urandom;
    {lo_e, lo_f, hi_e, hi_f} = $urandom;
  endtask

  // one cycle: inputs already driven after negedge; compare comb, then registered
  task automatic step(input int mode);
    logic [W:0] wide;
    #1;
    model();
    chk("R1", 64'(lut_out), 64'(e_lut));
    for (int i = 0; i < N; i++) begin
      chk("R2", 64'(sum_comb[2*i]), 64'(e_sum[2*i]));
      chk("R3", 64'(sum_comb[2*i+1]), 64'(e_sum[2*i+1]));
    end
    chk("R4", 64'(cout), 64'(e_cout));
    chk("R9", 64'(sum_reg), 64'(exp_reg));
    if (mode == 1) begin
      wide = {1'b0, pack_x()} + {1'b0, pack_y()} + (W+1)'(cin);
      chk("R5", 64'({cout, sum_comb}), 64'(wide));
    end
    if (mode == 2) chk("R8", 64'(cout), 64'(pack_x() >= pack_y()));
    @(posedge clk);
    if (rst) exp_reg = '0;
    else if (ce) exp_reg = e_sum;
    #1;
    chk(rst ? "R7" : "R6", 64'(sum_reg), 64'(exp_reg));
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1; ce = 1;
    step(0); step(0);

    // random masks and inputs, random enable
    rst = 0;
    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < 2*N; k++) mask[32*k +: 32] = $urandom;
      rand_side();
      cin = $urandom; ce = $urandom;
      step(0);
    end

    // single-index masks probe each input position
    for (int p = 0; p < 4; p++) begin
      logic [15:0] m;
      m = (p == 0) ? 16'hAAAA : (p == 1) ? 16'hCCCC : (p == 2) ? 16'hF0F0 : 16'hFF00;
      mask = {4*N{m}};
      for (int n = 0; n < 20; n++) begin rand_side(); cin = $urandom; ce = 1; step(0); end
    end

    // pass-through adder
    mask = {4*N{16'hFF00}};
    for (int n = 0; n < 300; n++) begin
      rand_side(); cin = $urandom; ce = $urandom; step(1);
    end
    set_ops('1, '0); cin = 1; ce = 1; step(1);
    set_ops('1, '1); cin = 1; step(1);
    set_ops('0, '0); cin = 0; step(1);

    // comparator, sum ignored, LUT outputs still checked
    mask = {2*N{16'h00FF, 16'hFF00}};
    cin = 1;
    for (int n = 0; n < 200; n++) begin rand_side(); ce = $urandom; step(2); end
    set_ops(8'h5A, 8'h5A); step(2);
    set_ops(8'h5A, 8'h5B); step(2);
    set_ops(8'h00, 8'hFF); step(2);
    set_ops(8'hFF, 8'h00); step(2);

    // enable low holds, then reset beats enable
    mask = {4*N{16'hFF00}};
    set_ops(8'h3C, 8'h11); cin = 0; ce = 1; step(1);
    ce = 0;
    for (int n = 0; n < 5; n++) begin rand_side(); step(1); end
    rst = 1; ce = 1; step(1);
    rst = 1; ce = 0; step(1);
    rst = 0; ce = 1; step(1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule